// File: doc/BRIEF.md
# Double-Buffered Audio Capture Controller

This block takes audio samples from a serial front end (already deserialized and brought into the system clock domain) and writes them to memory. Stereo samples of 16 or 32 bits, or raw bytes, are packed into 32-bit words and held in a capture FIFO. Whenever the FIFO holds a full burst of sixteen words (64 bytes), the block requests the memory bus. After the grant, it streams the burst on consecutive cycles.

Software provides two buffers, each given by a base address and a byte size. The fill position moves through the active buffer and then switches to the other one. The buffer just completed is flagged full until software gives it back.

Two sticky error flags stop sampling:
- **Overrun** is raised when a burst is ready but the target buffer is still full. Sampling resumes on any buffer release.
- **Bandwidth** is raised when a packed word meets a full FIFO. Sampling resumes as soon as the next burst is granted.

A single level interrupt combines the four status flags with their enable bits.

Register map (word index on `reg_addr`):
- 0: control
- 1: status on read, acknowledge on write
- 2: buffer 1 base
- 3: buffer 1 size
- 4: buffer 2 base
- 5: buffer 2 size

Top module: `audio_capture_ctrl`

## Requirements
- R1: After reset `irq` and `mem_req` are 0 and the control and status registers read 0.
- R2: Control bits [2:1]=0 selects stereo 16-bit mode. A sample with `smp_chan`=0 is held as the left sample. The next sample with `smp_chan`=1 completes the word {left[15:0], right[15:0]}. Upper input bits are ignored.
- R3: Control bits [2:1]=1 selects 32-bit mode, in which every accepted sample becomes one word in arrival order.
- R4: Control bits [2:1]=2 selects raw mode. Four consecutive bytes `smp_data[7:0]` form one word, with the first byte in bits [7:0] and the fourth in bits [31:24].
- R5: `mem_req` rises only when the FIFO holds at least 16 words. It presents `mem_addr` = active base + fill offset. One cycle after a grant, 16 words are delivered on consecutive `mem_wvalid` cycles in capture order.
- R6: Buffer 1 is filled first. When the fill offset reaches the active buffer's size, that buffer's full flag is set (status bit 0 for buffer 1, bit 1 for buffer 2). Filling then continues at offset 0 of the other buffer.
- R7: If a burst is ready while the active buffer is full, the overrun flag (status bit 3) is set, no request is made, and arriving samples are dropped. Sampling resumes after a write to address 1 with bit 0 or bit 1 set, which releases buffer 1 or buffer 2.
- R8: A packed word arriving while the FIFO already holds its 32 words sets the bandwidth flag (status bit 2) and is dropped. Later samples are dropped until the next burst is granted.
- R9: The bandwidth and overrun flags stay set until a write to address 1 with bit 2 (bandwidth) or bit 3 (overrun) set. Writing 0 to those bits has no effect.
- R10: `irq` is high exactly when some status flag bit n (n=0..3) is set together with control bit 4+n.
- R11: While control bit 0 (capture enable) is 0, samples are ignored and nothing reaches the FIFO.
- R12: A full flag stays set until its release bit is written, and the release clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index for reads and writes |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| smp_valid | input | 1 | One sample or byte is present this cycle |
| smp_chan | input | 1 | Channel of the sample, 0 left and 1 right |
| smp_data | input | DW | Sample value, or byte in bits [7:0] |
| mem_req | output | 1 | Burst write request |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_addr | output | AW | Byte address of the requested burst |
| mem_wvalid | output | 1 | A burst data beat is valid |
| mem_wdata | output | DW | Burst data beat |
| irq | output | 1 | Level interrupt |

## Verification
The assertions rely on three assumptions about the inputs:
- `mem_gnt` is only raised while `mem_req` is high.
- Registers are not rewritten in ways that break a stereo pair mid-way.
- Buffer sizes are multiples of 64 bytes.

The bench keeps to these assumptions:
- It grants only from a responder that watches `mem_req`.
- It changes the mode only on word boundaries.
- It uses 128-byte buffers.

Random sample values, including junk in the unused upper bits, are pushed through every mode. Directed sequences force the overrun and bandwidth halts.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    MODE_S16 = 2'd0,
    MODE_S32 = 2'd1,
    MODE_RAW = 2'd2,
    MODE_RSV = 2'd3
  } cap_mode_e;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_STAT  = 1;
  localparam int unsigned REG_BASE1 = 2;
  localparam int unsigned REG_SIZE1 = 3;
  localparam int unsigned REG_BASE2 = 4;
  localparam int unsigned REG_SIZE2 = 5;
endpackage

// File: rtl/cap_packer.sv
module cap_packer
  import cap_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  cap_mode_e    mode,
  input  logic         in_valid,
  input  logic         in_chan,
  input  logic [W-1:0] in_data,
  output logic         word_valid,
  output logic [W-1:0] word
);
  localparam int unsigned HALF  = W / 2;
  localparam int unsigned BYTES = W / 8;
  localparam int unsigned BC_W  = $clog2(BYTES);

  logic [W-1:0]    hold_q, hold_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            pend_q, pend_d;

  always_comb begin
    hold_d     = hold_q;
    bcnt_d     = bcnt_q;
    pend_d     = pend_q;
    word_valid = 1'b0;
    word       = in_data;
    if (clr) begin
      pend_d = 1'b0;
      bcnt_d = '0;
    end else if (in_valid) begin
      case (mode)
        MODE_S16: begin
          if (!in_chan) begin
            hold_d[HALF-1:0] = in_data[HALF-1:0];
            pend_d           = 1'b1;
          end else if (pend_q) begin
            word       = {hold_q[HALF-1:0], in_data[HALF-1:0]};
            word_valid = 1'b1;
            pend_d     = 1'b0;
          end
        end
        MODE_RAW: begin
          hold_d[{bcnt_q, 3'b000} +: 8] = in_data[7:0];
          if (bcnt_q == BC_W'(BYTES - 1)) begin
            word       = {in_data[7:0], hold_q[W-9:0]};
            word_valid = 1'b1;
            bcnt_d     = '0;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        default: word_valid = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    hold_q <= hold_d;
  end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_d;

  assign rdata = mem_q[rd_q];
  assign full  = (count == CNT_W'(DEPTH));

  always_comb begin
    wr_d  = push ? PTR_W'((32'(wr_q) + 1) % DEPTH) : wr_q;
    rd_d  = pop  ? PTR_W'((32'(rd_q) + 1) % DEPTH) : rd_q;
    cnt_d = count;
    if (push && !pop)      cnt_d = count + 1'b1;
    else if (pop && !push) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= wdata;
  end
endmodule

// File: rtl/cap_bufmgr.sv
module cap_bufmgr #(
  parameter int unsigned AW          = 32,
  parameter int unsigned W           = 32,
  parameter int unsigned BURST_WORDS = 16,
  parameter int unsigned CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    base1,
  input  logic [AW-1:0]    size1,
  input  logic [AW-1:0]    base2,
  input  logic [AW-1:0]    size2,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic             mem_gnt,
  input  logic [1:0]       release_buf,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             beat,
  output logic [1:0]       buf_full,
  output logic             ovr_evt,
  output logic             gnt_take
);
  localparam int unsigned BURST_BYTES = BURST_WORDS * W / 8;
  localparam int unsigned BEAT_W      = $clog2(BURST_WORDS);

  logic              stream_q, stream_d;
  logic [BEAT_W-1:0] bcnt_q, bcnt_d;
  logic              sel_q, sel_d;
  logic [AW-1:0]     off_q, off_d, next_off, cur_size;
  logic [1:0]        full_d;
  logic              ready, last;

  assign ready    = !stream_q && (fifo_cnt >= CNT_W'(BURST_WORDS));
  assign mem_req  = ready && !buf_full[sel_q];
  assign ovr_evt  = ready && buf_full[sel_q];
  assign gnt_take = mem_req && mem_gnt;
  assign mem_addr = (sel_q ? base2 : base1) + off_q;
  assign beat     = stream_q;
  assign last     = stream_q && (bcnt_q == BEAT_W'(BURST_WORDS - 1));
  assign next_off = off_q + AW'(BURST_BYTES);
  assign cur_size = sel_q ? size2 : size1;

  always_comb begin
    stream_d = stream_q;
    bcnt_d   = bcnt_q;
    sel_d    = sel_q;
    off_d    = off_q;
    full_d   = buf_full & ~release_buf;
    if (last) begin
      stream_d = 1'b0;
      bcnt_d   = '0;
      if (next_off >= cur_size) begin
        full_d[sel_q] = 1'b1;
        sel_d         = ~sel_q;
        off_d         = '0;
      end else begin
        off_d = next_off;
      end
    end else if (stream_q) begin
      bcnt_d = bcnt_q + 1'b1;
    end else if (gnt_take) begin
      stream_d = 1'b1;
      bcnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_q <= 1'b0;
      bcnt_q   <= '0;
      sel_q    <= 1'b0;
      off_q    <= '0;
      buf_full <= '0;
    end else begin
      stream_q <= stream_d;
      bcnt_q   <= bcnt_d;
      sel_q    <= sel_d;
      off_q    <= off_d;
      buf_full <= full_d;
    end
  end
endmodule

// File: rtl/audio_capture_ctrl.sv
module audio_capture_ctrl
  import cap_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 32,
  parameter int unsigned RA_W        = 3,
  parameter int unsigned FIFO_DEPTH  = 32,
  parameter int unsigned BURST_WORDS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            smp_valid,
  input  logic            smp_chan,
  input  logic [DW-1:0]   smp_data,
  output logic            mem_req,
  input  logic            mem_gnt,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_wvalid,
  output logic [DW-1:0]   mem_wdata,
  output logic            irq
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic          en_q, en_d;
  cap_mode_e     mode_q, mode_d;
  logic [3:0]    ie_q, ie_d;
  logic [AW-1:0] base1_q, base1_d, size1_q, size1_d;
  logic [AW-1:0] base2_q, base2_d, size2_q, size2_d;
  logic          bw_q, bw_d, ovr_q, ovr_d;
  logic          hbw_q, hbw_d, hovr_q, hovr_d;

  logic             wr_ctrl, wr_stat, sampling;
  logic [1:0]       release_buf, buf_full;
  logic             word_valid, fifo_push, fifo_full, beat;
  logic [DW-1:0]    word;
  logic [CNT_W-1:0] fifo_cnt;
  logic             bw_evt, ovr_evt, gnt_take;
  logic [3:0]       flags;

  assign wr_ctrl     = reg_wr_en && (reg_addr == RA_W'(REG_CTRL));
  assign wr_stat     = reg_wr_en && (reg_addr == RA_W'(REG_STAT));
  assign release_buf = wr_stat ? reg_wdata[1:0] : 2'b00;
  assign sampling    = en_q && !hbw_q && !hovr_q;
  assign fifo_push   = word_valid && (!fifo_full || beat);
  assign bw_evt      = word_valid && fifo_full && !beat;
  assign flags       = {ovr_q, bw_q, buf_full};
  assign irq         = |(flags & ie_q);
  assign mem_wvalid  = beat;

  cap_packer #(.W(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(!sampling), .mode(mode_q),
    .in_valid(smp_valid && sampling), .in_chan(smp_chan), .in_data(smp_data),
    .word_valid(word_valid), .word(word)
  );

  cap_fifo #(.W(DW), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(word), .pop(beat),
    .rdata(mem_wdata), .count(fifo_cnt), .full(fifo_full)
  );

  cap_bufmgr #(.AW(AW), .W(DW), .BURST_WORDS(BURST_WORDS), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .base1(base1_q), .size1(size1_q),
    .base2(base2_q), .size2(size2_q), .fifo_cnt(fifo_cnt), .mem_gnt(mem_gnt),
    .release_buf(release_buf), .mem_req(mem_req), .mem_addr(mem_addr),
    .beat(beat), .buf_full(buf_full), .ovr_evt(ovr_evt), .gnt_take(gnt_take)
  );

  always_comb begin
    case (32'(reg_addr))
      REG_CTRL:  reg_rdata = DW'({ie_q, 1'b0, mode_q, en_q});
      REG_STAT:  reg_rdata = DW'(flags);
      REG_BASE1: reg_rdata = DW'(base1_q);
      REG_SIZE1: reg_rdata = DW'(size1_q);
      REG_BASE2: reg_rdata = DW'(base2_q);
      REG_SIZE2: reg_rdata = DW'(size2_q);
      default:   reg_rdata = '0;
    endcase
  end

  always_comb begin
    en_d    = en_q;
    mode_d  = mode_q;
    ie_d    = ie_q;
    base1_d = base1_q;
    size1_d = size1_q;
    base2_d = base2_q;
    size2_d = size2_q;
    if (wr_ctrl) begin
      en_d   = reg_wdata[0];
      mode_d = cap_mode_e'(reg_wdata[2:1]);
      ie_d   = reg_wdata[7:4];
    end
    if (reg_wr_en && reg_addr == RA_W'(REG_BASE1)) base1_d = reg_wdata[AW-1:0];
    if (reg_wr_en && reg_addr == RA_W'(REG_SIZE1)) size1_d = reg_wdata[AW-1:0];
    if (reg_wr_en && reg_addr == RA_W'(REG_BASE2)) base2_d = reg_wdata[AW-1:0];
    if (reg_wr_en && reg_addr == RA_W'(REG_SIZE2)) size2_d = reg_wdata[AW-1:0];
    bw_d   = bw_evt  ? 1'b1 : ((wr_stat && reg_wdata[2]) ? 1'b0 : bw_q);
    ovr_d  = ovr_evt ? 1'b1 : ((wr_stat && reg_wdata[3]) ? 1'b0 : ovr_q);
    hbw_d  = gnt_take ? 1'b0 : (bw_evt ? 1'b1 : hbw_q);
    hovr_d = (|release_buf) ? 1'b0 : (ovr_evt ? 1'b1 : hovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= MODE_S16;
      ie_q    <= '0;
      base1_q <= '0;
      size1_q <= '0;
      base2_q <= '0;
      size2_q <= '0;
      bw_q    <= 1'b0;
      ovr_q   <= 1'b0;
      hbw_q   <= 1'b0;
      hovr_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      ie_q    <= ie_d;
      base1_q <= base1_d;
      size1_q <= size1_d;
      base2_q <= base2_d;
      size2_q <= size2_d;
      bw_q    <= bw_d;
      ovr_q   <= ovr_d;
      hbw_q   <= hbw_d;
      hovr_q  <= hovr_d;
    end
  end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int unsigned BURST_WORDS = 16,
  parameter int unsigned DEPTH       = 32,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned RA_W        = 3,
  parameter int unsigned DW          = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_gnt,
  input logic             mem_wvalid,
  input logic             irq,
  input logic [3:0]       flags,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fifo_push,
  input logic             sampling,
  input logic             reg_wr_en,
  input logic [RA_W-1:0]  reg_addr,
  input logic [DW-1:0]    reg_wdata
);
  logic [CNT_W-1:0] run_q;
  logic             ack_wr;

  assign ack_wr = reg_wr_en && (reg_addr == RA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (mem_wvalid) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  assert_req_has_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (fifo_cnt >= CNT_W'(BURST_WORDS)));

  assert_grant_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> mem_wvalid);

  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wvalid) |-> (run_q == CNT_W'(BURST_WORDS)));

  assert_no_req_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !mem_req);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_halt_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sampling |-> !fifo_push);

  assert_bw_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !(ack_wr && reg_wdata[2])) |=> flags[2]);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3] && !(ack_wr && reg_wdata[3])) |=> flags[3]);

  assert_full_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(ack_wr && reg_wdata[0])) |=> flags[0]);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'b0000) |-> !irq);
endmodule

bind audio_capture_ctrl cap_checker #(
  .BURST_WORDS(BURST_WORDS), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .RA_W(RA_W), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_wvalid(mem_wvalid), .irq(irq), .flags(flags), .fifo_cnt(fifo_cnt),
  .fifo_push(fifo_push), .sampling(sampling), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/audio_capture_ctrl_test.sv
`timescale 1ns/1ps
module audio_capture_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        smp_valid, smp_chan;
  logic [31:0] smp_data;
  logic        mem_req, mem_gnt, mem_wvalid, irq;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0;
  int errors = 0;
  bit gnt_on = 1'b1;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  logic [31:0] adr_q[$];

  always #2.5 clk = ~clk;

  audio_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .irq(irq)
  );

  localparam logic [31:0] EN = 32'h1, S16 = 32'h0, S32 = 32'h2, RAW = 32'h4;

  always @(negedge clk) begin
    if (mem_wvalid) got_q.push_back(mem_wdata);
    if (gnt_on && mem_req && !mem_gnt) begin
      mem_gnt = 1'b1;
      adr_q.push_back(mem_addr);
    end else begin
      mem_gnt = 1'b0;
    end
  end

  function automatic logic [31:0] pack16(logic [31:0] l, logic [31:0] r);
    return {l[15:0], r[15:0]};
  endfunction

  function automatic logic [31:0] pack_raw(logic [31:0] b0, b1, b2, b3);
    return {b3[7:0], b2[7:0], b1[7:0], b0[7:0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic smp(input logic ch, input logic [31:0] d);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send32(input int n, input bit keep);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = $urandom;
      smp(1'($urandom), d);
      if (keep) exp_q.push_back(d);
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && got_q.size() < exp_q.size(); i++) tick(1);
    tick(3);
    check(req, got_q.size(), exp_q.size());
    while (exp_q.size() > 0 && got_q.size() > 0) check(req, got_q.pop_front(), exp_q.pop_front());
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic check_adr(input string req, input logic [31:0] exp);
    if (adr_q.size() == 0) check(req, 32'hdead_0000, exp);
    else check(req, adr_q.pop_front(), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    smp_valid = 1'b0; smp_chan = 1'b0; smp_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 mem_req", mem_req, 0);
    rd(1, v); check("R1 status", v, 0);
    rd(0, v); check("R1 ctrl", v, 0);

    wr(2, 32'h1000); wr(3, 128); wr(4, 32'h2000); wr(5, 128);

    // R11 capture disabled: samples ignored
    wr(0, S32);
    send32(20, 0);
    tick(5);
    check("R11 mem_req", mem_req, 0);
    check("R11 no beats", got_q.size(), 0);

    // R2 stereo 16-bit packing, first burst at base1
    wr(0, EN | S16);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] l, r;
      l = $urandom; r = $urandom;
      smp(1'b0, l); smp(1'b1, r);
      exp_q.push_back(pack16(l, r));
    end
    drain("R2 stereo16 word");
    check_adr("R5 burst address", 32'h1000);
    rd(1, v); check("R6 buffer1 not yet full", v, 0);

    // R3 32-bit mode, second burst fills buffer 1
    wr(0, EN | S32 | 32'hF0);
    send32(16, 1);
    drain("R3 stereo32 word");
    check_adr("R5 second offset", 32'h1040);
    rd(1, v); check("R6 buffer1 full", v, 32'h1);
    check("R10 irq on full1", irq, 1);
    wr(0, EN | S32 | 32'h20);
    tick(1);
    check("R10 irq masked", irq, 0);

    // R4 raw bytes into buffer 2
    wr(0, EN | RAW | 32'h20);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b0, b1, b2, b3;
      b0 = $urandom; b1 = $urandom; b2 = $urandom; b3 = $urandom;
      smp(1'b0, b0); smp(1'b1, b1); smp(1'b0, b2); smp(1'b1, b3);
      exp_q.push_back(pack_raw(b0, b1, b2, b3));
    end
    drain("R4 raw word");
    check_adr("R6 switch to base2", 32'h2000);
    check_adr("R6 base2 offset", 32'h2040);
    rd(1, v); check("R6 both full", v, 32'h3);
    check("R10 irq on full2", irq, 1);

    // R7 overrun: both buffers full
    wr(0, EN | S32);
    send32(16, 1);
    tick(5);
    rd(1, v); check("R7 overrun flag", v, 32'hB);
    check("R7 no request", mem_req, 0);
    send32(8, 0);
    wr(1, 32'h1);
    drain("R7 resumed burst");
    check_adr("R7 resume address", 32'h1000);
    rd(1, v); check("R12 release clears full1", v[0], 0);
    check("R9 overrun sticky", v[3], 1);
    wr(1, 32'h0);
    rd(1, v); check("R9 zero write no effect", v[3], 1);
    wr(1, 32'h8);
    rd(1, v); check("R9 overrun ack", v[3], 0);
    send32(16, 1);
    drain("R7 dropped samples absent");
    check_adr("R6 buffer1 second half", 32'h1040);
    rd(1, v); check("R12 full1 set again", v, 32'h3);
    wr(1, 32'h3);
    rd(1, v); check("R12 release both", v, 0);

    // R8 bandwidth error: FIFO full without grants
    gnt_on = 1'b0;
    send32(32, 1);
    send32(5, 0);
    tick(2);
    rd(1, v); check("R8 bandwidth flag", v, 32'h4);
    gnt_on = 1'b1;
    drain("R8 kept words");
    check_adr("R8 first burst", 32'h2000);
    check_adr("R8 second burst", 32'h2040);
    send32(16, 1);
    drain("R8 sampling resumed");
    check_adr("R8 third burst", 32'h1000);
    rd(1, v); check("R9 bandwidth sticky", v[2], 1);
    wr(1, 32'h4);
    rd(1, v); check("R9 bandwidth ack", v[2], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule